// File: doc/BRIEF.md
# Cascaded Serial DAC Chain Host

This block is the host-side master for a string of dual-channel 12-bit serial DACs. The DACs are wired as a daisy chain: the host's data line feeds the first device, and each device's return line feeds the next. The host takes one request. The request holds a pair of codes for every device, an update-mode bit and a clock-divider setting. The block turns it into a single chip-select-low frame with SCLK idling low, and then commits the new codes in one of two ways. In the first, every device loads its latches when chip-select returns high, with the load line held low. In the second, a separate load strobe is pulsed low after chip-select has risen.

Every minimum timing is a parameter in nanoseconds, and the block turns each one into a whole number of system clocks, rounded up. These minimums are the SCLK half period, the chip-select setup, the chip-select high time between frames, and the load-strobe delay and width. The request can slow SCLK further, for example when a pulled-up open-drain return needs extra settling. While the frame is sent, the return line from the far end of the chain is sampled on each SCLK rising edge. This gives the words the devices held before the write. A busy/done handshake tells the requester when a new request may start.

Top module: `dacchain_host`

## Requirements
- R1: Out of reset and whenever busy is low, cs_n=1, sclk=0 and ldac_n=1.
- R2: One request makes one frame of NDEV*24 SCLK rising edges with cs_n low. mosi is stable at each rising edge and changes only after a falling edge. mosi sends req_codes from bit NDEV*24-1 down to bit 0, so the word in bits [24k+23:24k] ends up in device k, counted from the host (the farthest device's word goes first).
- R3: Inside each 24-bit word, bits [23:12] hold the channel-B code and bits [11:0] hold the channel-A code, each sent MSB first.
- R4: Every SCLK high phase lasts exactly H system clocks, and so does every low phase between two rising edges. H = max(req_half, ceil(T_HALF_NS/CLK_NS)); req_half is sampled when the request is accepted.
- R5: The first SCLK rising edge comes at least ceil(T_CSS_NS/CLK_NS) clocks, and at least H clocks, after cs_n falls.
- R6: After a frame, cs_n stays high with busy still high for at least ceil(T_GAP_NS/CLK_NS) clocks. Consecutive frames are separated by at least that many cs_n-high clocks.
- R7: With req_mode=0 (update on chip-select rise), ldac_n goes low together with cs_n falling. It stays low through the whole chip-select-high interval after the frame, and returns high when done pulses.
- R8: With req_mode=1 (strobe update), ldac_n is high when cs_n rises. It falls exactly ceil(T_LDD_NS/CLK_NS) clocks after that, stays low exactly ceil(T_LDW_NS/CLK_NS) clocks, and no device latch changes before it falls.
- R9: When done pulses, rb_data holds the miso bits sampled at the frame's SCLK rising edges, the first sample at bit NDEV*24-1. For a chain this is the previous request's req_codes (all zeros after power-up).
- R10: A request is accepted only while busy is low, and busy is high from the next clock on. done is a one-clock pulse in the clock where busy falls. A request raised while busy has no effect on the frame, the latches or rb_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_mode | input | 1 | 0: update on chip-select rise, 1: separate load strobe |
| req_half | input | DIV_W | Requested SCLK half period in system clocks (raised to the minimum) |
| req_codes | input | NDEV*24 | Per-device words, device k in bits [24k+23:24k] |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rb_data | output | NDEV*24 | Read-back words sampled from miso |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the first device |
| ldac_n | output | 1 | Load strobe, active low |
| miso | input | 1 | Return line from the last device in the chain |

## Verification
The bench places a behavioural chain of two devices on the pins and checks each device's latch against the word meant for it. A frame sent in reverse device order, or with the channel fields swapped, would leave the wrong latch contents. The SCLK phases, the chip-select setup and gap, and the strobe delay and width are measured in system clocks, with requested half periods below, at and above the floor. Any rounding error or off-by-one in a counter shows up there. In strobe mode the bench checks that the latches still hold the old codes when the strobe falls, which catches an update leaking at chip-select rise. It also raises a second request in the middle of a transfer, which would corrupt both the latches and the read-back if it were accepted.

// File: rtl/dacchain_pkg.sv
package dacchain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_GAP,
        ST_LDWAIT,
        ST_LDPULSE,
        ST_TAIL
    } dc_state_e;

    typedef enum logic {
        UPD_CSRISE = 1'b0,
        UPD_STROBE = 1'b1
    } upd_mode_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic ldac_n;
    } pins_t;

    function automatic int ns_to_cyc(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacchain_tmr.sv
module dacchain_tmr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    assign zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (load)  cnt_q <= val;
        else if (!zero) cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/dacchain_sreg.sv
module dacchain_sreg #(
    parameter int FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_val,
    input  logic               tx_shift,
    input  logic               rx_sample,
    input  logic               rx_bit,
    output logic               tx_bit,
    output logic [FRAME_W-1:0] rx_word
);
    logic [FRAME_W-1:0] tx_q;
    logic [FRAME_W-1:0] rx_q;

    assign tx_bit  = tx_q[FRAME_W-1];
    assign rx_word = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load)          tx_q <= load_val;
            else if (tx_shift) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            if (load)           rx_q <= '0;
            else if (rx_sample) rx_q <= {rx_q[FRAME_W-2:0], rx_bit};
        end
    end
endmodule

// File: rtl/dacchain_host.sv
module dacchain_host
    import dacchain_pkg::*;
#(
    parameter int NDEV      = 2,
    parameter int CODE_W    = 12,
    parameter int CLK_NS    = 8,
    parameter int DIV_W     = 8,
    parameter int T_HALF_NS = 80,
    parameter int T_CSS_NS  = 50,
    parameter int T_GAP_NS  = 120,
    parameter int T_LDD_NS  = 100,
    parameter int T_LDW_NS  = 60
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_mode,
    input  logic [DIV_W-1:0]            req_half,
    input  logic [NDEV*2*CODE_W-1:0]    req_codes,
    output logic                        busy,
    output logic                        done,
    output logic [NDEV*2*CODE_W-1:0]    rb_data,
    output logic                        cs_n,
    output logic                        sclk,
    output logic                        mosi,
    output logic                        ldac_n,
    input  logic                        miso
);
    localparam int WORD_W  = 2 * CODE_W;
    localparam int FRAME_W = NDEV * WORD_W;
    localparam int BIT_W   = $clog2(FRAME_W + 1);
    localparam int HALF_C  = ns_to_cyc(T_HALF_NS, CLK_NS);
    localparam int CSS_C   = ns_to_cyc(T_CSS_NS, CLK_NS);
    localparam int GAP_C   = ns_to_cyc(T_GAP_NS, CLK_NS);
    localparam int LDD_C   = ns_to_cyc(T_LDD_NS, CLK_NS);
    localparam int LDW_C   = ns_to_cyc(T_LDW_NS, CLK_NS);
    localparam int TAIL_C  = imax(GAP_C - LDD_C - LDW_C, 0);
    localparam int CNT_W   = imax(DIV_W, $clog2(imax(imax(GAP_C, LDD_C),
                                 imax(LDW_C, imax(CSS_C, HALF_C))) + 1));

    localparam logic [CNT_W-1:0] HALF_V = CNT_W'(HALF_C);
    localparam logic [CNT_W-1:0] CSS_V  = CNT_W'(CSS_C);
    localparam logic [CNT_W-1:0] GAP_V  = CNT_W'(GAP_C - 1);
    localparam logic [CNT_W-1:0] LDD_V  = CNT_W'(LDD_C - 1);
    localparam logic [CNT_W-1:0] LDW_V  = CNT_W'(LDW_C - 1);
    localparam logic [CNT_W-1:0] TAIL_V = CNT_W'(imax(TAIL_C - 1, 0));
    localparam logic [BIT_W-1:0] LAST_B = BIT_W'(FRAME_W - 1);

    dc_state_e        st_q, st_d;
    pins_t            pin_q, pin_d;
    logic             busy_q, busy_d, done_q, done_d;
    upd_mode_e        mode_q;
    logic [CNT_W-1:0] half_q, half_eff, setup_len, req_half_w;
    logic [BIT_W-1:0] bit_q, bit_d;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic             sr_load, sr_shift, sr_sample, accept;

    assign req_half_w = CNT_W'(req_half);
    assign half_eff   = (req_half_w < HALF_V) ? HALF_V : req_half_w;
    assign setup_len  = (half_eff < CSS_V) ? CSS_V : half_eff;
    assign accept     = (st_q == ST_IDLE) && req_valid;

    dacchain_tmr #(.W(CNT_W)) tmr_i (
        .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
    );

    dacchain_sreg #(.FRAME_W(FRAME_W)) sreg_i (
        .clk(clk), .rst(rst), .load(sr_load), .load_val(req_codes),
        .tx_shift(sr_shift), .rx_sample(sr_sample), .rx_bit(miso),
        .tx_bit(mosi), .rx_word(rb_data)
    );

    always_comb begin
        st_d      = st_q;
        pin_d     = pin_q;
        busy_d    = busy_q;
        done_d    = 1'b0;
        bit_d     = bit_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sr_load   = 1'b0;
        sr_shift  = 1'b0;
        sr_sample = 1'b0;
        case (st_q)
            ST_IDLE: if (accept) begin
                st_d         = ST_SETUP;
                pin_d.cs_n   = 1'b0;
                pin_d.ldac_n = req_mode;
                busy_d       = 1'b1;
                bit_d        = '0;
                sr_load      = 1'b1;
                tmr_load     = 1'b1;
                tmr_val      = setup_len - 1'b1;
            end
            ST_SETUP, ST_LOW: if (tmr_zero) begin
                st_d       = ST_HIGH;
                pin_d.sclk = 1'b1;
                sr_sample  = 1'b1;
                tmr_load   = 1'b1;
                tmr_val    = half_q - 1'b1;
            end
            ST_HIGH: if (tmr_zero) begin
                pin_d.sclk = 1'b0;
                tmr_load   = 1'b1;
                if (bit_q == LAST_B) begin
                    pin_d.cs_n = 1'b1;
                    st_d       = (mode_q == UPD_STROBE) ? ST_LDWAIT : ST_GAP;
                    tmr_val    = (mode_q == UPD_STROBE) ? LDD_V : GAP_V;
                end else begin
                    st_d     = ST_LOW;
                    sr_shift = 1'b1;
                    bit_d    = bit_q + 1'b1;
                    tmr_val  = half_q - 1'b1;
                end
            end
            ST_LDWAIT: if (tmr_zero) begin
                st_d         = ST_LDPULSE;
                pin_d.ldac_n = 1'b0;
                tmr_load     = 1'b1;
                tmr_val      = LDW_V;
            end
            ST_LDPULSE: if (tmr_zero) begin
                pin_d.ldac_n = 1'b1;
                if (TAIL_C > 0) begin
                    st_d     = ST_TAIL;
                    tmr_load = 1'b1;
                    tmr_val  = TAIL_V;
                end else begin
                    st_d   = ST_IDLE;
                    busy_d = 1'b0;
                    done_d = 1'b1;
                end
            end
            ST_GAP, ST_TAIL: if (tmr_zero) begin
                st_d         = ST_IDLE;
                pin_d.ldac_n = 1'b1;
                busy_d       = 1'b0;
                done_d       = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pin_q  <= '{cs_n: 1'b1, sclk: 1'b0, ldac_n: 1'b1};
            busy_q <= 1'b0;
            done_q <= 1'b0;
            bit_q  <= '0;
            mode_q <= UPD_CSRISE;
            half_q <= HALF_V;
        end else begin
            st_q   <= st_d;
            pin_q  <= pin_d;
            busy_q <= busy_d;
            done_q <= done_d;
            bit_q  <= bit_d;
            if (accept) begin
                mode_q <= upd_mode_e'(req_mode);
                half_q <= half_eff;
            end
        end
    end

    assign cs_n   = pin_q.cs_n;
    assign sclk   = pin_q.sclk;
    assign ldac_n = pin_q.ldac_n;
    assign busy   = busy_q;
    assign done   = done_q;
endmodule

// File: rtl/dacchain_host_chk.sv
module dacchain_host_chk
    import dacchain_pkg::*;
#(
    parameter int CLK_NS    = 8,
    parameter int T_HALF_NS = 80,
    parameter int T_CSS_NS  = 50,
    parameter int T_GAP_NS  = 120,
    parameter int T_LDD_NS  = 100,
    parameter int T_LDW_NS  = 60
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic cs_n,
    input logic sclk,
    input logic ldac_n
);
    localparam logic [15:0] HALF_M = 16'(ns_to_cyc(T_HALF_NS, CLK_NS));
    localparam logic [15:0] CSS_M  = 16'(ns_to_cyc(T_CSS_NS, CLK_NS));
    localparam logic [15:0] GAP_M  = 16'(ns_to_cyc(T_GAP_NS, CLK_NS));
    localparam logic [15:0] LDD_M  = 16'(ns_to_cyc(T_LDD_NS, CLK_NS));
    localparam logic [15:0] LDW_M  = 16'(ns_to_cyc(T_LDW_NS, CLK_NS));

    logic [15:0] hi_cnt, lo_cnt, cs_hi_cnt, ld_lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt    <= '0;
            lo_cnt    <= '0;
            cs_hi_cnt <= 16'hFFFF;
            ld_lo_cnt <= '0;
        end else begin
            hi_cnt    <= sclk ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1) : '0;
            lo_cnt    <= (!sclk && !cs_n) ? ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1) : '0;
            cs_hi_cnt <= cs_n ? ((cs_hi_cnt == 16'hFFFF) ? cs_hi_cnt : cs_hi_cnt + 1'b1) : '0;
            ld_lo_cnt <= !ldac_n ? ((ld_lo_cnt == 16'hFFFF) ? ld_lo_cnt : ld_lo_cnt + 1'b1) : '0;
        end
    end

    AST_IDLE_PINS:    assert property (@(posedge clk) disable iff (rst) !busy |-> (cs_n && !sclk && ldac_n)); // R1
    AST_SCLK_IN_CS:   assert property (@(posedge clk) disable iff (rst) $rose(sclk) |-> !cs_n); // R2
    AST_HIGH_WIDTH:   assert property (@(posedge clk) disable iff (rst) $fell(sclk) |-> hi_cnt >= HALF_M); // R4
    AST_LOW_WIDTH:    assert property (@(posedge clk) disable iff (rst) $rose(sclk) |-> lo_cnt >= HALF_M); // R4
    AST_CS_SETUP:     assert property (@(posedge clk) disable iff (rst) $rose(sclk) |-> lo_cnt >= CSS_M); // R5
    AST_CS_GAP:       assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> cs_hi_cnt >= GAP_M); // R6
    AST_LD_DELAY:     assert property (@(posedge clk) disable iff (rst) ($fell(ldac_n) && cs_n) |-> cs_hi_cnt >= LDD_M); // R8
    AST_LD_WIDTH:     assert property (@(posedge clk) disable iff (rst) $rose(ldac_n) |-> ld_lo_cnt >= LDW_M); // R8
    AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R10
    AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
    AST_BUSY_ON_REQ:  assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(req_valid)); // R10
endmodule

bind dacchain_host dacchain_host_chk #(
    .CLK_NS(CLK_NS), .T_HALF_NS(T_HALF_NS), .T_CSS_NS(T_CSS_NS),
    .T_GAP_NS(T_GAP_NS), .T_LDD_NS(T_LDD_NS), .T_LDW_NS(T_LDW_NS)
) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy), .done(done),
    .cs_n(cs_n), .sclk(sclk), .ldac_n(ldac_n)
);

// File: tb/dacchain_host_tb.sv
module dacchain_host_tb_top;
    localparam int NDEV    = 2;
    localparam int FRAME_W = NDEV * 24;
    localparam int MINH    = 10;  // ceil(80/8)
    localparam int CSS     = 7;   // ceil(50/8)
    localparam int GAPC    = 15;  // ceil(120/8)
    localparam int LDD     = 13;  // ceil(100/8)
    localparam int LDW     = 8;   // ceil(60/8)

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_mode = 1'b0;
    logic [7:0] req_half = '0;
    logic [FRAME_W-1:0] req_codes = '0;
    logic busy, done, cs_n, sclk, mosi, ldac_n, miso;
    logic [FRAME_W-1:0] rb_data;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dacchain_host dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_half(req_half), .req_codes(req_codes), .busy(busy), .done(done),
        .rb_data(rb_data), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .ldac_n(ldac_n), .miso(miso)
    );

    // behavioural chain of devices
    logic [23:0] dev_sh  [NDEV] = '{default: '0};
    logic [23:0] dev_lat [NDEV] = '{default: '0};
    logic        dev_do  [NDEV] = '{default: 1'b0};

    always @(posedge sclk)
        if (!cs_n)
            for (int k = 0; k < NDEV; k++)
                dev_sh[k] <= {dev_sh[k][22:0], (k == 0) ? mosi : dev_do[(k == 0) ? 0 : k - 1]};

    always @(negedge sclk)
        for (int k = 0; k < NDEV; k++) dev_do[k] <= dev_sh[k][23];

    always @(posedge clk)
        if (cs_n && !ldac_n)
            for (int k = 0; k < NDEV; k++) dev_lat[k] <= dev_sh[k];

    assign miso = dev_do[NDEV-1];

    function automatic logic [FRAME_W-1:0] lat_word();
        logic [FRAME_W-1:0] w;
        for (int k = 0; k < NDEV; k++) w[24*k +: 24] = dev_lat[k];
        return w;
    endfunction

    function automatic int exp_half(input int req);
        return (req < MINH) ? MINH : req;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // pin monitor
    logic p_sclk = 1'b0, p_cs = 1'b1, p_ld = 1'b1;
    int rises, hi_run, lo_run, hi_min, hi_max, lo_min, lo_max, first_lo;
    int cs_hi_run = 100000, ld_dly, ld_w, ld_ph, tail, frames = 0;
    logic ld_at_rise;
    logic [FRAME_W-1:0] lat_before_ld;

    always @(negedge clk) if (!rst) begin
        if (p_cs && !cs_n) begin
            if (frames > 0) chk(cs_hi_run >= GAPC, "R6 cs gap", cs_hi_run, GAPC);
            frames++;
            rises = 0; hi_min = 100000; hi_max = 0; lo_min = 100000; lo_max = 0;
            hi_run = 0; lo_run = 0; first_lo = 0;
        end
        if (!cs_n && !sclk) lo_run++;
        if (sclk) hi_run++;
        if (sclk && !p_sclk) begin
            if (rises == 0) first_lo = lo_run;
            else begin
                if (lo_run < lo_min) lo_min = lo_run;
                if (lo_run > lo_max) lo_max = lo_run;
            end
            rises++;
            lo_run = 0;
        end
        if (!sclk && p_sclk) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
            if (!cs_n) lo_run = 1;
        end
        if (cs_n && !p_cs) begin
            ld_at_rise = ldac_n;
            cs_hi_run = 1;
            ld_dly = ldac_n ? 1 : 0;
            ld_w = 0; ld_ph = ldac_n ? 0 : 3;
            tail = busy ? 1 : 0;
        end else if (cs_n) begin
            cs_hi_run++;
            if (busy) tail++;
            if (ld_ph == 0) begin
                if (ldac_n) ld_dly++;
                else begin ld_ph = 1; ld_w = 1; lat_before_ld = lat_word(); end
            end else if (ld_ph == 1) begin
                if (!ldac_n) ld_w++; else ld_ph = 2;
            end
        end
        p_sclk = sclk; p_cs = cs_n; p_ld = ldac_n;
    end

    logic [FRAME_W-1:0] prev_codes = '0;

    task automatic run_txn(input logic [FRAME_W-1:0] codes, input bit mode,
                           input logic [7:0] half, input bit interfere);
        int h;
        h = exp_half(int'(half));
        @(negedge clk);
        req_valid = 1'b1; req_mode = mode; req_half = half; req_codes = codes;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        if (interfere) begin
            repeat (40) @(negedge clk);
            req_valid = 1'b1; req_mode = ~mode; req_half = 8'd200; req_codes = ~codes;
            repeat (3) @(negedge clk);
            req_valid = 1'b0; req_codes = codes;
        end
        while (!done) @(negedge clk);
        chk(busy == 1'b0, "R10 busy low with done", busy, 0);
        for (int k = 0; k < NDEV; k++) begin
            chk(dev_lat[k] == codes[24*k +: 24], "R2 device latch", dev_lat[k], codes[24*k +: 24]);
            chk(dev_lat[k][23:12] == codes[24*k+12 +: 12], "R3 channel B field",
                dev_lat[k][23:12], codes[24*k+12 +: 12]);
            chk(dev_lat[k][11:0] == codes[24*k +: 12], "R3 channel A field",
                dev_lat[k][11:0], codes[24*k +: 12]);
        end
        chk(rb_data == prev_codes, "R9 read-back", rb_data, prev_codes);
        chk(rises == FRAME_W, "R2 rising edge count", rises, FRAME_W);
        chk(hi_min == h && hi_max == h, "R4 high phase", hi_max, h);
        chk(lo_min == h && lo_max == h, "R4 low phase", lo_max, h);
        chk(first_lo >= CSS && first_lo >= h, "R5 cs setup", first_lo, h);
        chk(tail >= GAPC, "R6 busy through gap", tail, GAPC);
        if (!mode) begin
            chk(ld_at_rise == 1'b0, "R7 ldac low at cs rise", ld_at_rise, 0);
        end else begin
            chk(ld_at_rise == 1'b1, "R8 ldac high at cs rise", ld_at_rise, 1);
            chk(ld_dly == LDD, "R8 strobe delay", ld_dly, LDD);
            chk(ld_w == LDW, "R8 strobe width", ld_w, LDW);
            chk(lat_before_ld == prev_codes, "R8 no early update", lat_before_ld, prev_codes);
        end
        if (interfere) chk(lat_word() == codes, "R10 request while busy ignored", lat_word(), codes);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
        chk(ldac_n && cs_n && !sclk, "R1 idle pins", {ldac_n, cs_n, sclk}, 3'b110);
        prev_codes = codes;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog act=busy exp=done");
        finish_run();
    end

    initial begin
        logic [FRAME_W-1:0] c;
        void'($urandom(32'd24601));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && !sclk && ldac_n && !busy && !done, "R1 reset state",
            {cs_n, sclk, ldac_n, busy, done}, 5'b10100);
        chk(rb_data == '0, "R9 reset read-back", rb_data, 0);
        run_txn({24'hFFF_FFF, 24'hFFF_FFF}, 1'b0, 8'd0, 1'b0);
        run_txn({24'h800_001, 24'h7FF_FFE}, 1'b1, 8'd10, 1'b0);
        run_txn({24'hABC_123, 24'h456_DEF}, 1'b0, 8'd11, 1'b0);
        run_txn({24'h000_000, 24'hFFF_000}, 1'b1, 8'd32, 1'b0);
        run_txn({24'h5A5_A5A, 24'h3C3_C3C}, 1'b0, 8'd9, 1'b1);
        run_txn({24'h123_456, 24'h789_ABC}, 1'b1, 8'd1, 1'b1);
        for (int i = 0; i < 12; i++) begin
            c = {$urandom(), $urandom()};
            run_txn(c, 1'($urandom() & 1), 8'($urandom() % 40), 1'b0);
        end
        finish_run();
    end
endmodule